// File: doc/BRIEF.md
# Split-Cache Internal Snoop Controller

This block keeps a separate instruction cache and data cache coherent with each other. When the fetch side or the load/store side misses, the miss is handed to the controller. The controller asks the opposite side to look the line up. From the hit and modified status that comes back, it runs one of a small set of response sequences. A sequence may write back, invalidate, release the access unchanged, release it as non-cacheable, mark it as served by forwarded data, or request a pipeline flush.

The opposite side's tag lookup, the writeback path and the invalidate path each use a request/acknowledge handshake. The controller holds each request high until it is acknowledged. Only one snoop is in flight at a time. While a sequence runs, `req_ready` is low and any request offered on the input is ignored.

The access kind is a 2-bit code: 00 is an instruction fetch, 01 is a data read and 10 is a data write. The reserved code 11 is handled as a data read. For the side select, 0 names the data side (data cache, store buffer and writeback buffer). 1 names the instruction side (instruction cache, prefetch cache and line-fill buffer).

Top module: `xsnoop_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `lk_valid`, `wb_req`, `inv_req`, `go_valid` and `flush_valid` are all 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` then stays 0 until the cycle after the `go_valid` pulse. Requests offered while it is 0 have no effect on the sequence or on the released address and kind.
- R3: On a lookup miss (`lk_hit`=0), `go_valid` is high for exactly one cycle: the cycle after the one in which `lk_done` was seen. It carries the original kind and address, with `go_uncached`=0 and `go_fwd`=0, and no writeback or invalidate is requested.
- R4: For an instruction fetch (kind 00) that hits a modified line (`lk_dirty`=1), `wb_req` is raised first. An invalidate follows its acknowledge. The fetch is then released for retry with `go_fwd`=1, meaning the written-back data was passed to the instruction side and no separate line fill is needed.
- R5: For an instruction fetch that hits a clean line, the line is invalidated with no writeback request, and the fetch is released for retry with `go_fwd`=0.
- R6: For a data read (kind 01) that hits, whatever the value of `lk_dirty`, no invalidate and no writeback are requested. The read is released in the cycle after the lookup result with `go_uncached`=1.
- R7: For a data write (kind 10) that hits, whatever the value of `lk_dirty`, the instruction-side line is invalidated with no writeback, and the write is then released with `go_uncached`=0.
- R8: `flush_valid` pulses for exactly one cycle, in the cycle after the lookup result, only for a data-write hit. `flush_tag` equals the tag given with the request.
- R9: `lk_side` and `inv_side` are 0 (data side) for an instruction fetch and 1 (instruction side) for a data access. `lk_addr`, `wb_addr` and `inv_addr` equal the accepted request address.
- R10: `wb_req` and `inv_req` stay high, with a stable address, until their acknowledge is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Controller idle, request can be accepted |
| req_kind | input | 2 | Access kind: 00 fetch, 01 data read, 10 data write |
| req_addr | input | AW | Line address of the miss |
| req_tag | input | TW | Tag of the instruction that caused the miss |
| lk_valid | output | 1 | Lookup request to the opposite side |
| lk_side | output | 1 | Side looked up: 0 data, 1 instruction |
| lk_addr | output | AW | Lookup address |
| lk_done | input | 1 | Lookup result valid |
| lk_hit | input | 1 | Line present on the looked-up side |
| lk_dirty | input | 1 | Line is modified |
| wb_req | output | 1 | Writeback request for the data-side line |
| wb_addr | output | AW | Writeback address |
| wb_ack | input | 1 | Writeback done |
| inv_req | output | 1 | Invalidate request |
| inv_side | output | 1 | Side to invalidate: 0 data, 1 instruction |
| inv_addr | output | AW | Invalidate address |
| inv_ack | input | 1 | Invalidate done |
| go_valid | output | 1 | Original access released (one-cycle pulse) |
| go_kind | output | 2 | Kind of the released access |
| go_addr | output | AW | Address of the released access |
| go_uncached | output | 1 | Perform as a single non-cacheable access |
| go_fwd | output | 1 | Fetch served by forwarded writeback data |
| flush_valid | output | 1 | Flush request for younger instructions (one-cycle pulse) |
| flush_tag | output | TW | Tag of the instruction that caused the snoop |

## Verification
The bench sweeps every access kind against hit and miss, modified and clean, and several lookup and acknowledge latencies. It also offers a different request throughout each busy period. A controller that wrote back clean lines or data-side writes would raise a `wb_req` that is never expected. One that invalidated on a data-read hit would destroy a line the instruction side still needs. One that dropped the forward flag, or put the invalidate before the writeback, would be caught by the order check and by the `go_fwd` check. A controller that latched a request while busy would release the wrong address. A flush that lasted more than one cycle, or that fired on a read hit, would fail the per-cycle flush checks.

// File: rtl/xsnoop_pkg.sv
package xsnoop_pkg;

    typedef enum logic [1:0] {
        ACC_IFETCH = 2'b00,
        ACC_DREAD  = 2'b01,
        ACC_DWRITE = 2'b10,
        ACC_RSVD   = 2'b11
    } acc_kind_e;

    localparam logic SIDE_DATA = 1'b0;
    localparam logic SIDE_INST = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOOK = 3'd1,
        ST_WB   = 3'd2,
        ST_INV  = 3'd3,
        ST_REL  = 3'd4
    } seq_st_e;

    typedef struct packed {
        logic do_wb;
        logic do_inv;
        logic uncached;
        logic flush;
    } snoop_plan_t;

    // Response chosen from the miss kind and the opposite side's lookup.
    function automatic snoop_plan_t plan_for(acc_kind_e k, logic hit, logic dirty);
        snoop_plan_t p;
        p = '0;
        if (hit) begin
            unique case (k)
                ACC_IFETCH: begin
                    p.do_wb  = dirty;
                    p.do_inv = 1'b1;
                end
                ACC_DWRITE: begin
                    p.do_inv = 1'b1;
                    p.flush  = 1'b1;
                end
                default: begin
                    p.uncached = 1'b1;
                end
            endcase
        end
        return p;
    endfunction

    function automatic logic peer_of(acc_kind_e k);
        return (k == ACC_IFETCH) ? SIDE_DATA : SIDE_INST;
    endfunction

endpackage

// File: rtl/xsnoop_capture.sv
module xsnoop_capture #(
    parameter int AW = 32,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [1:0]    kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] tag_i,
    output logic [1:0]    kind_o,
    output logic [AW-1:0] addr_o,
    output logic [TW-1:0] tag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_o <= '0;
            addr_o <= '0;
            tag_o  <= '0;
        end else if (load) begin
            kind_o <= kind_i;
            addr_o <= addr_i;
            tag_o  <= tag_i;
        end
    end

endmodule

// File: rtl/xsnoop_seq.sv
module xsnoop_seq
    import xsnoop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  acc_kind_e cur_kind,
    input  logic      lk_done,
    input  logic      lk_hit,
    input  logic      lk_dirty,
    input  logic      wb_ack,
    input  logic      inv_ack,
    output logic      req_ready,
    output logic      load,
    output logic      lk_valid,
    output logic      wb_req,
    output logic      inv_req,
    output logic      go_valid,
    output logic      go_uncached,
    output logic      go_fwd,
    output logic      flush_fire
);

    seq_st_e     st_q;
    snoop_plan_t plan_now;
    logic        unc_q;
    logic        fwd_q;

    assign plan_now = plan_for(cur_kind, lk_hit, lk_dirty);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            unc_q <= 1'b0;
            fwd_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        st_q  <= ST_LOOK;
                        unc_q <= 1'b0;
                        fwd_q <= 1'b0;
                    end
                end
                ST_LOOK: begin
                    if (lk_done) begin
                        unc_q <= plan_now.uncached;
                        if (plan_now.do_wb)       st_q <= ST_WB;
                        else if (plan_now.do_inv) st_q <= ST_INV;
                        else                      st_q <= ST_REL;
                    end
                end
                ST_WB: begin
                    if (wb_ack) begin
                        fwd_q <= 1'b1;
                        st_q  <= ST_INV;
                    end
                end
                ST_INV: begin
                    if (inv_ack) st_q <= ST_REL;
                end
                ST_REL:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready   = (st_q == ST_IDLE);
        load        = req_ready && req_valid;
        lk_valid    = (st_q == ST_LOOK);
        wb_req      = (st_q == ST_WB);
        inv_req     = (st_q == ST_INV);
        go_valid    = (st_q == ST_REL);
        go_uncached = go_valid && unc_q;
        go_fwd      = go_valid && fwd_q;
        flush_fire  = lk_valid && lk_done && plan_now.flush;
    end

    // R2: once accepted, the controller is busy
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R10: handshakes hold until acknowledged
    a_r10_wb_hold: assert property (@(posedge clk) disable iff (rst)
        wb_req && !wb_ack |=> wb_req);
    a_r10_inv_hold: assert property (@(posedge clk) disable iff (rst)
        inv_req && !inv_ack |=> inv_req);

    // R4: an acknowledged writeback is followed by the invalidate
    a_r4_inv_after_wb: assert property (@(posedge clk) disable iff (rst)
        wb_req && wb_ack |=> inv_req && !wb_req);

    // R3: release is a single pulse, then idle
    a_r3_release_pulse: assert property (@(posedge clk) disable iff (rst)
        go_valid |=> !go_valid && req_ready);

    // R6: a non-cacheable release never claims forwarded data
    a_r6_unc_no_fwd: assert property (@(posedge clk) disable iff (rst)
        go_valid |-> !(go_uncached && go_fwd));

endmodule

// File: rtl/xsnoop_flush.sv
module xsnoop_flush #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [TW-1:0] tag_i,
    output logic          flush_valid,
    output logic [TW-1:0] flush_tag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_valid <= 1'b0;
            flush_tag   <= '0;
        end else begin
            flush_valid <= fire;
            if (fire) flush_tag <= tag_i;
        end
    end

    // R8: the flush request lasts one cycle
    a_r8_flush_single: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> !flush_valid);

endmodule

// File: rtl/xsnoop_ctrl.sv
module xsnoop_ctrl
    import xsnoop_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [TW-1:0] req_tag,
    output logic          lk_valid,
    output logic          lk_side,
    output logic [AW-1:0] lk_addr,
    input  logic          lk_done,
    input  logic          lk_hit,
    input  logic          lk_dirty,
    output logic          wb_req,
    output logic [AW-1:0] wb_addr,
    input  logic          wb_ack,
    output logic          inv_req,
    output logic          inv_side,
    output logic [AW-1:0] inv_addr,
    input  logic          inv_ack,
    output logic          go_valid,
    output logic [1:0]    go_kind,
    output logic [AW-1:0] go_addr,
    output logic          go_uncached,
    output logic          go_fwd,
    output logic          flush_valid,
    output logic [TW-1:0] flush_tag
);

    logic          load;
    logic          flush_fire;
    logic [1:0]    cap_kind;
    logic [AW-1:0] cap_addr;
    logic [TW-1:0] cap_tag;
    acc_kind_e     cur_kind;

    xsnoop_capture #(.AW(AW), .TW(TW)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .kind_i (req_kind),
        .addr_i (req_addr),
        .tag_i  (req_tag),
        .kind_o (cap_kind),
        .addr_o (cap_addr),
        .tag_o  (cap_tag)
    );

    assign cur_kind = acc_kind_e'(cap_kind);

    xsnoop_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .cur_kind    (cur_kind),
        .lk_done     (lk_done),
        .lk_hit      (lk_hit),
        .lk_dirty    (lk_dirty),
        .wb_ack      (wb_ack),
        .inv_ack     (inv_ack),
        .req_ready   (req_ready),
        .load        (load),
        .lk_valid    (lk_valid),
        .wb_req      (wb_req),
        .inv_req     (inv_req),
        .go_valid    (go_valid),
        .go_uncached (go_uncached),
        .go_fwd      (go_fwd),
        .flush_fire  (flush_fire)
    );

    xsnoop_flush #(.TW(TW)) u_flush (
        .clk         (clk),
        .rst         (rst),
        .fire        (flush_fire),
        .tag_i       (cap_tag),
        .flush_valid (flush_valid),
        .flush_tag   (flush_tag)
    );

    assign lk_side  = peer_of(cur_kind);
    assign inv_side = peer_of(cur_kind);
    assign lk_addr  = cap_addr;
    assign wb_addr  = cap_addr;
    assign inv_addr = cap_addr;
    assign go_kind  = cap_kind;
    assign go_addr  = cap_addr;

    // R10: the writeback address is stable while waiting for acknowledge
    a_r10_wb_addr_stable: assert property (@(posedge clk) disable iff (rst)
        wb_req && !wb_ack |=> $stable(wb_addr));

    // R9: the writeback always targets the data side
    a_r9_wb_data_side: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> lk_side == SIDE_DATA);

endmodule

// File: tb/xsnoop_ctrl_bench.sv
module xsnoop_ctrl_bench;

    localparam int AW = 8;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] req_tag = '0;
    logic          lk_valid, lk_side;
    logic [AW-1:0] lk_addr;
    logic          lk_done = 1'b0, lk_hit = 1'b0, lk_dirty = 1'b0;
    logic          wb_req;
    logic [AW-1:0] wb_addr;
    logic          wb_ack = 1'b0;
    logic          inv_req, inv_side;
    logic [AW-1:0] inv_addr;
    logic          inv_ack = 1'b0;
    logic          go_valid;
    logic [1:0]    go_kind;
    logic [AW-1:0] go_addr;
    logic          go_uncached, go_fwd;
    logic          flush_valid;
    logic [TW-1:0] flush_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xsnoop_ctrl #(.AW(AW), .TW(TW)) u_xsnoop_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_tag(req_tag),
        .lk_valid(lk_valid), .lk_side(lk_side), .lk_addr(lk_addr),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_dirty(lk_dirty),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .inv_req(inv_req), .inv_side(inv_side), .inv_addr(inv_addr), .inv_ack(inv_ack),
        .go_valid(go_valid), .go_kind(go_kind), .go_addr(go_addr),
        .go_uncached(go_uncached), .go_fwd(go_fwd),
        .flush_valid(flush_valid), .flush_tag(flush_tag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_one(input int kind, input int hit, input int dirty,
                           input int lkd, input int ackd,
                           input logic [AW-1:0] addr, input logic [TW-1:0] tag);
        bit peer  = (kind != 0);
        bit ewb   = (kind == 0) && hit && dirty;
        bit einv  = hit && (kind != 1);
        bit eunc  = hit && (kind == 1);
        bit eflsh = hit && (kind == 2);
        bit seen_wb = 0, seen_inv = 0, got_go = 0;
        int wcnt = 0, icnt = 0;

        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_addr  = addr;
        req_tag   = tag;
        @(negedge clk);
        chk(req_ready == 1'b0, "R2", "ready after accept", int'(req_ready), 0);
        chk(lk_valid == 1'b1, "R9", "lookup raised", int'(lk_valid), 1);
        chk(lk_side == peer, "R9", "lookup side", int'(lk_side), int'(peer));
        chk(lk_addr == addr, "R9", "lookup addr", int'(lk_addr), int'(addr));
        // offer a different request while busy: must be ignored
        req_kind = 2'((kind + 1) % 3);
        req_addr = ~addr;
        req_tag  = ~tag;
        for (int i = 0; i < lkd; i++) begin
            @(negedge clk);
            chk(lk_valid == 1'b1, "R9", "lookup held", int'(lk_valid), 1);
        end
        lk_done  = 1'b1;
        lk_hit   = 1'(hit);
        lk_dirty = 1'(dirty);
        @(negedge clk);
        lk_done = 1'b0;
        for (int idx = 0; idx < 40; idx++) begin
            wb_ack  = 1'b0;
            inv_ack = 1'b0;
            if (idx == 0) begin
                chk(flush_valid == eflsh, "R8", "flush after lookup", int'(flush_valid), int'(eflsh));
                if (eflsh)
                    chk(flush_tag == tag, "R8", "flush tag", int'(flush_tag), int'(tag));
                if (!ewb && !einv)
                    chk(go_valid == 1'b1, "R3", "release one cycle after lookup", int'(go_valid), 1);
            end else begin
                chk(flush_valid == 1'b0, "R8", "flush single cycle", int'(flush_valid), 0);
            end
            if (go_valid) begin
                got_go = 1;
                chk(go_kind == 2'(kind), "R2", "released kind", int'(go_kind), kind);
                chk(go_addr == addr, "R2", "released addr", int'(go_addr), int'(addr));
                chk(go_uncached == eunc, "R6", "uncached flag", int'(go_uncached), int'(eunc));
                chk(go_fwd == ewb, "R4", "forward flag", int'(go_fwd), int'(ewb));
                chk(seen_wb == ewb, "R5", "writeback occurrence", int'(seen_wb), int'(ewb));
                chk(seen_inv == einv, "R7", "invalidate occurrence", int'(seen_inv), int'(einv));
                chk(!(wb_req || inv_req), "R3", "no request at release",
                    int'(wb_req || inv_req), 0);
                req_valid = 1'b0;
                break;
            end
            if (wb_req) begin
                if (!seen_wb) begin
                    chk(wb_addr == addr, "R9", "writeback addr", int'(wb_addr), int'(addr));
                    chk(seen_inv == 0, "R4", "writeback before invalidate", int'(seen_inv), 0);
                end
                seen_wb = 1;
                if (wcnt == ackd) wb_ack = 1'b1;
                else wcnt++;
            end
            if (inv_req) begin
                if (!seen_inv) begin
                    chk(inv_side == peer, "R9", "invalidate side", int'(inv_side), int'(peer));
                    chk(inv_addr == addr, "R10", "invalidate addr", int'(inv_addr), int'(addr));
                end
                seen_inv = 1;
                if (icnt == ackd) inv_ack = 1'b1;
                else icnt++;
            end
            @(negedge clk);
        end
        wb_ack  = 1'b0;
        inv_ack = 1'b0;
        req_valid = 1'b0;
        chk(got_go, "R3", "release seen", int'(got_go), 1);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready after release", int'(req_ready), 1);
        chk(go_valid == 1'b0, "R3", "release pulse ends", int'(go_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
        chk(lk_valid == 1'b0, "R1", "lk_valid", int'(lk_valid), 0);
        chk(wb_req == 1'b0, "R1", "wb_req", int'(wb_req), 0);
        chk(inv_req == 1'b0, "R1", "inv_req", int'(inv_req), 0);
        chk(go_valid == 1'b0, "R1", "go_valid", int'(go_valid), 0);
        chk(flush_valid == 1'b0, "R1", "flush_valid", int'(flush_valid), 0);
        for (int k = 0; k < 3; k++)
            for (int h = 0; h < 2; h++)
                for (int d = 0; d < 2; d++)
                    for (int lat = 0; lat < 3; lat++)
                        run_one(k, h, d, lat, (lat + k) % 3,
                                AW'(k * 37 + h * 11 + d * 5 + lat * 3 + 1),
                                TW'(k * 5 + h * 3 + d + lat));
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule